// File: doc/BRIEF.md
# Bus Interface Parity Checker and Generator

This block sits between a DMA engine and a shared on-chip bus and handles all of the byte-lane parity on that boundary. When the bus addresses the engine's registers, the block checks the incoming address against its parity and flags a mismatch with a bus error pulse. When the engine drives its own requests, the block generates address parity before the address reaches the bus.

Data parity is mostly passed through. Register write data, read return data from the memory controller, initiator write data and read completions all cross the block with their parity bits unchanged. The single exception is a read completion tagged as a descriptor fetch. For those, every byte lane is verified, and a mismatch sets a sticky error flag. Software or the channel logic clears the flag with a write-one-to-clear strobe.

All data paths are combinational. The only state in the block is the descriptor error flag.

Top module: `bus_parity_if`

## Requirements
- R1: Parity is even and per byte lane. Lane i covers bits [8i+7:8i] and its parity bit is bit i of the parity vector. A lane is in error when the XOR of its eight bits and its parity bit is 1.
- R2: While `tgt_addr_vld_i` is 1, `tgt_bus_err_o` is 1 in the same cycle exactly when any lane of `tgt_addr_i` mismatches `tgt_addr_par_i`. While `tgt_addr_vld_i` is 0, `tgt_bus_err_o` is 0 whatever the address and parity.
- R3: Target write data parity is never checked. `reg_wdata_o` and `reg_wpar_o` equal `tgt_wdata_i` and `tgt_wpar_i` in the same cycle. A parity mismatch on them raises neither `tgt_bus_err_o` nor `desc_par_err_o`.
- R4: With `bus_dout_sel_i`=1, `bus_dout_o`/`bus_dout_par_o` carry `mem_rd_data_i`/`mem_rd_par_i` unchanged. With `bus_dout_sel_i`=0, they carry `ini_wdata_i`/`ini_wpar_i` unchanged. Data parity is never regenerated.
- R5: `ini_bus_addr_o` equals `ini_addr_i`, and `ini_bus_addr_par_o` is the even parity of each of its lanes, in the same cycle.
- R6: `mem_cpl_vld_o`, `mem_cpl_data_o` and `mem_cpl_par_o` equal `cpl_vld_i`, `cpl_data_i` and `cpl_par_i` in the same cycle, for both tag values.
- R7: A completion with `cpl_desc_i`=0 never sets `desc_par_err_o`, even when its parity mismatches.
- R8: A completion with `cpl_vld_i`=1, `cpl_desc_i`=1 and any lane mismatching sets `desc_par_err_o` from the cycle after its clock edge. A descriptor completion with correct parity leaves the flag at 0.
- R9: `desc_par_err_o` holds its value until a clock edge with `desc_err_clr_i`=1 clears it. If a set and a clear fall on the same edge, the set wins.
- R10: After `rst_ni` is asserted, `desc_par_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tgt_addr_vld_i | input | 1 | Target address phase valid |
| tgt_addr_i | input | 32 | Target address from bus |
| tgt_addr_par_i | input | 4 | Target address parity from bus |
| tgt_bus_err_o | output | 1 | Address parity error pulse |
| tgt_wdata_i | input | 64 | Target write data from bus |
| tgt_wpar_i | input | 8 | Target write data parity from bus |
| reg_wdata_o | output | 64 | Write data to registers |
| reg_wpar_o | output | 8 | Write data parity to registers |
| bus_dout_sel_i | input | 1 | 1: target read return, 0: initiator write |
| mem_rd_data_i | input | 64 | Read return data from memory controller |
| mem_rd_par_i | input | 8 | Read return parity from memory controller |
| ini_wdata_i | input | 64 | Initiator write data from memory controller |
| ini_wpar_i | input | 8 | Initiator write parity from memory controller |
| bus_dout_o | output | 64 | Data driven onto bus |
| bus_dout_par_o | output | 8 | Parity driven onto bus |
| ini_addr_i | input | 32 | Initiator request address |
| ini_bus_addr_o | output | 32 | Initiator address onto bus |
| ini_bus_addr_par_o | output | 4 | Generated initiator address parity |
| cpl_vld_i | input | 1 | Read completion valid from bus |
| cpl_desc_i | input | 1 | Completion belongs to a descriptor fetch |
| cpl_data_i | input | 64 | Completion data from bus |
| cpl_par_i | input | 8 | Completion parity from bus |
| mem_cpl_vld_o | output | 1 | Completion valid to memory controller |
| mem_cpl_data_o | output | 64 | Completion data to memory controller |
| mem_cpl_par_o | output | 8 | Completion parity to memory controller |
| desc_err_clr_i | input | 1 | Write-one-to-clear for descriptor flag |
| desc_par_err_o | output | 1 | Sticky descriptor parity error flag |

## Verification
Every pass-through path, the generated address parity and the target bus error are combinational. The bench drives these inputs on a falling edge, waits a short settle delay and checks in the same low phase, so no rising edge lies between stimulus and sample. The descriptor flag has one register. Its set and clear effects are checked at the falling edge after the rising edge that captures them, and a further cycle is checked to confirm the flag holds.

// File: rtl/bus_par_pkg.sv
package bus_par_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lanes(input int unsigned width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/byte_par_gen.sv
module byte_par_gen #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LANES = bus_par_pkg::lanes(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  output logic [LANES-1:0] par_o
);
  import bus_par_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // even parity: bit makes lane plus parity have even weight
    assign par_o[l] = ^data_i[l*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/lane_par_chk.sv
module lane_par_chk #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned LANES = bus_par_pkg::lanes(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LANES-1:0] par_i,
  output logic [LANES-1:0] lane_bad_o,
  output logic             any_bad_o
);
  logic [LANES-1:0] exp_par;

  byte_par_gen #(.WIDTH(WIDTH)) u_gen (
    .data_i(data_i),
    .par_o (exp_par)
  );

  assign lane_bad_o = exp_par ^ par_i;
  assign any_bad_o  = |lane_bad_o;
endmodule

// File: rtl/desc_err_flag.sv
module desc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/bus_parity_if.sv
module bus_parity_if #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned AP_W = bus_par_pkg::lanes(ADDR_W),
  localparam int unsigned DP_W = bus_par_pkg::lanes(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_addr_vld_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [AP_W-1:0]   tgt_addr_par_i,
  output logic              tgt_bus_err_o,
  input  logic [DATA_W-1:0] tgt_wdata_i,
  input  logic [DP_W-1:0]   tgt_wpar_i,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [DP_W-1:0]   reg_wpar_o,
  input  logic              bus_dout_sel_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  input  logic [DP_W-1:0]   mem_rd_par_i,
  input  logic [DATA_W-1:0] ini_wdata_i,
  input  logic [DP_W-1:0]   ini_wpar_i,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic [DP_W-1:0]   bus_dout_par_o,
  input  logic [ADDR_W-1:0] ini_addr_i,
  output logic [ADDR_W-1:0] ini_bus_addr_o,
  output logic [AP_W-1:0]   ini_bus_addr_par_o,
  input  logic              cpl_vld_i,
  input  logic              cpl_desc_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  input  logic [DP_W-1:0]   cpl_par_i,
  output logic              mem_cpl_vld_o,
  output logic [DATA_W-1:0] mem_cpl_data_o,
  output logic [DP_W-1:0]   mem_cpl_par_o,
  input  logic              desc_err_clr_i,
  output logic              desc_par_err_o
);
  import bus_par_pkg::*;

  // target address check
  logic [AP_W-1:0] addr_lane_bad;
  logic            addr_bad;

  lane_par_chk #(.WIDTH(ADDR_W)) u_addr_chk (
    .data_i    (tgt_addr_i),
    .par_i     (tgt_addr_par_i),
    .lane_bad_o(addr_lane_bad),
    .any_bad_o (addr_bad)
  );

  assign tgt_bus_err_o = tgt_addr_vld_i & addr_bad;

  // target write data: no check
  assign reg_wdata_o = tgt_wdata_i;
  assign reg_wpar_o  = tgt_wpar_i;

  // bus data out mux, parity forwarded
  always_comb begin
    if (bus_dout_sel_i) begin
      bus_dout_o     = mem_rd_data_i;
      bus_dout_par_o = mem_rd_par_i;
    end else begin
      bus_dout_o     = ini_wdata_i;
      bus_dout_par_o = ini_wpar_i;
    end
  end

  // initiator address parity generation
  assign ini_bus_addr_o = ini_addr_i;
  byte_par_gen #(.WIDTH(ADDR_W)) u_addr_gen (
    .data_i(ini_addr_i),
    .par_o (ini_bus_addr_par_o)
  );

  // completions: forward, check only descriptor fetches
  logic [DP_W-1:0] cpl_lane_bad;
  logic            cpl_bad;

  lane_par_chk #(.WIDTH(DATA_W)) u_cpl_chk (
    .data_i    (cpl_data_i),
    .par_i     (cpl_par_i),
    .lane_bad_o(cpl_lane_bad),
    .any_bad_o (cpl_bad)
  );

  assign mem_cpl_vld_o  = cpl_vld_i;
  assign mem_cpl_data_o = cpl_data_i;
  assign mem_cpl_par_o  = cpl_par_i;

  desc_err_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cpl_vld_i & cpl_desc_i & cpl_bad),
    .clr_i (desc_err_clr_i),
    .flag_o(desc_par_err_o)
  );

  assert_err_needs_vld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_addr_vld_i |-> !tgt_bus_err_o);

  for (genvar l = 0; l < AP_W; l++) begin : g_addr_chk
    assert_gen_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (^{ini_bus_addr_o[l*BYTE_W +: BYTE_W], ini_bus_addr_par_o[l]}) == 1'b0);
  end
endmodule

// File: tb/bus_parity_if_test.sv
`timescale 1ns/1ps
module bus_parity_if_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tgt_addr_vld_i = 0;
  logic [31:0] tgt_addr_i = '0;
  logic [3:0]  tgt_addr_par_i = '0;
  logic        tgt_bus_err_o;
  logic [63:0] tgt_wdata_i = '0;
  logic [7:0]  tgt_wpar_i = '0;
  logic [63:0] reg_wdata_o;
  logic [7:0]  reg_wpar_o;
  logic        bus_dout_sel_i = 0;
  logic [63:0] mem_rd_data_i = '0;
  logic [7:0]  mem_rd_par_i = '0;
  logic [63:0] ini_wdata_i = '0;
  logic [7:0]  ini_wpar_i = '0;
  logic [63:0] bus_dout_o;
  logic [7:0]  bus_dout_par_o;
  logic [31:0] ini_addr_i = '0;
  logic [31:0] ini_bus_addr_o;
  logic [3:0]  ini_bus_addr_par_o;
  logic        cpl_vld_i = 0;
  logic        cpl_desc_i = 0;
  logic [63:0] cpl_data_i = '0;
  logic [7:0]  cpl_par_i = '0;
  logic        mem_cpl_vld_o;
  logic [63:0] mem_cpl_data_o;
  logic [7:0]  mem_cpl_par_o;
  logic        desc_err_clr_i = 0;
  logic        desc_par_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  bus_parity_if uut (.*);

  // {addr, addr_par, expected error}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {32'h0000_0000, 4'b0000, 1'b0},
    {32'h0000_00FF, 4'b0000, 1'b0},
    {32'h0000_0001, 4'b0001, 1'b0},
    {32'h0102_0304, 4'b1101, 1'b0},
    {32'h0102_0304, 4'b1100, 1'b1},
    {32'h8000_0000, 4'b1000, 1'b0},
    {32'h8000_0000, 4'b0000, 1'b1},
    {32'hFFFF_FFFF, 4'b0000, 1'b0},
    {32'hFFFF_FFFF, 4'b1111, 1'b1}
  };

  function automatic logic [7:0] epar64(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) p[l] = ^d[l*8 +: 8];
    return p;
  endfunction

  function automatic logic [3:0] epar32(input logic [31:0] d);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) p[l] = ^d[l*8 +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpl(input logic desc, input logic [63:0] d, input logic [7:0] p);
    @(negedge clk_i);
    cpl_vld_i = 1; cpl_desc_i = desc; cpl_data_i = d; cpl_par_i = p;
    #1;
    chk("R6 cpl vld", 64'(mem_cpl_vld_o), 64'd1);
    chk("R6 cpl data", mem_cpl_data_o, d);
    chk("R6 cpl par", 64'(mem_cpl_par_o), 64'(p));
    @(negedge clk_i);
    cpl_vld_i = 0; cpl_desc_i = 0;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (2) @(negedge clk_i);
    chk("R10 reset flag", 64'(desc_par_err_o), 64'd0);
    rst_ni = 1;

    // R1/R2 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      tgt_addr_vld_i = 1;
      tgt_addr_i = VEC[i][36:5];
      tgt_addr_par_i = VEC[i][4:1];
      #1 chk("R1 R2 addr check", 64'(tgt_bus_err_o), 64'(VEC[i][0]));
      tgt_addr_vld_i = 0;
      #1 chk("R2 no vld no err", 64'(tgt_bus_err_o), 64'd0);
    end

    // R5 initiator address parity
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      ini_addr_i = 32'h1357_9BDF * (i + 1) ^ (32'hA5 << i);
      #1;
      chk("R5 addr out", 64'(ini_bus_addr_o), 64'(ini_addr_i));
      chk("R5 addr par", 64'(ini_bus_addr_par_o), 64'(epar32(ini_addr_i)));
    end

    // R4 data out mux
    @(negedge clk_i);
    mem_rd_data_i = 64'hDEAD_BEEF_0123_4567; mem_rd_par_i = 8'h5A;
    ini_wdata_i = 64'hCAFE_F00D_89AB_CDEF; ini_wpar_i = 8'hC3;
    bus_dout_sel_i = 1;
    #1;
    chk("R4 read return data", bus_dout_o, 64'hDEAD_BEEF_0123_4567);
    chk("R4 read return par", 64'(bus_dout_par_o), 64'h5A);
    bus_dout_sel_i = 0;
    #1;
    chk("R4 ini write data", bus_dout_o, 64'hCAFE_F00D_89AB_CDEF);
    chk("R4 ini write par", 64'(bus_dout_par_o), 64'hC3);

    // R3 target write data not checked
    @(negedge clk_i);
    tgt_wdata_i = 64'h0000_0000_0000_0001; tgt_wpar_i = 8'h00;
    #1;
    chk("R3 reg data", reg_wdata_o, 64'h1);
    chk("R3 reg par", 64'(reg_wpar_o), 64'h0);
    chk("R3 no bus err", 64'(tgt_bus_err_o), 64'd0);
    @(negedge clk_i);
    chk("R3 no flag", 64'(desc_par_err_o), 64'd0);

    // R7 non-descriptor bad parity
    d = 64'h0011_2233_4455_6677;
    cpl(1'b0, d, ~epar64(d));
    chk("R7 no flag", 64'(desc_par_err_o), 64'd0);

    // R8 good descriptor
    d = 64'hFEDC_BA98_7654_3210;
    cpl(1'b1, d, epar64(d));
    chk("R8 good desc no flag", 64'(desc_par_err_o), 64'd0);

    // R8 bad lane 7 only
    cpl(1'b1, d, epar64(d) ^ 8'h80);
    chk("R8 flag set", 64'(desc_par_err_o), 64'd1);

    // R9 sticky then clear
    @(negedge clk_i);
    chk("R9 sticky", 64'(desc_par_err_o), 64'd1);
    desc_err_clr_i = 1;
    @(negedge clk_i);
    desc_err_clr_i = 0;
    chk("R9 cleared", 64'(desc_par_err_o), 64'd0);

    // R9 set wins over clear
    @(negedge clk_i);
    cpl_vld_i = 1; cpl_desc_i = 1; cpl_data_i = d; cpl_par_i = epar64(d) ^ 8'h01;
    desc_err_clr_i = 1;
    @(negedge clk_i);
    cpl_vld_i = 0; cpl_desc_i = 0; desc_err_clr_i = 0;
    chk("R9 set wins", 64'(desc_par_err_o), 64'd1);

    // R10 reset clears flag
    rst_ni = 0;
    #1 chk("R10 async reset", 64'(desc_par_err_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule